// File: doc/BRIEF.md
# Predicated Vector Compare-Branch Unit

This unit decides whether a vector branch is taken. After a one-cycle start pulse it walks a vector of up to VL element pairs, one element per clock. Each element whose effective source predicate bit is set is compared, and the outcome is recorded as one bit of a result mask. After the walk, a consensus rule turns the mask into a single taken flag. The rule can be all pass, any fails, any passes or none pass.

A destination predicate is optional. When it is present, its invert and zeroing flags select the consensus rule, and the final mask is offered for write-back with a one-cycle write enable. Fail-on-first mode ends the walk at the first active element that fails. Otherwise every element up to VL is visited. The branch target, register fetch and pipeline refill are handled elsewhere.

Top module: `vcmp_branch`

## Requirements
- R1: While rst_ni is low and after it is released, done_o, dpred_we_o, taken_o and result_o are all zero until the first finished evaluation.
- R2: Element compare codes on cmp_op_i are: 0 equal, 1 not equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than, 7 unsigned greater-or-equal. Codes 2 and 3 never pass.
- R3: The effective source mask ps is spred_mask_i, bitwise complemented when spred_inv_i is 1, and limited to bits below VL. An element with a ps bit of 0 is not compared and leaves its result bit at its initial value.
- R4: The result mask starts with its low VL bits all ones when dpred_en_i is 0 or spred_zero_i is 1. Otherwise it starts as all zeros. Bits at VL and above are always zero.
- R5: For each active element i, bit i of result_o is set if the compare passes and cleared if it fails.
- R6: When ffirst_i is 1, the walk ends at the first active element whose compare fails; that bit is cleared, and later elements are untouched.
- R7: The rule code {invert, zeroing} is {dpred_inv_i, dpred_zero_i}. Rule 00 branches when (result & ps) == result, 10 when (result & ps) != result, 01 when result != 0, and 11 when result == 0.
- R8: With dpred_en_i at 0 the rule is 00 and dpred_we_o stays low. With dpred_en_i at 1, dpred_we_o is high exactly in the done cycle, alongside the final mask.
- R9: done_o is high for one cycle. It rises n+1 clock edges after the edge that samples start_i, where n is the number of elements visited: VL, or the index of the stopping element plus one.
- R10: After done_o, result_o and taken_o hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| vl_i | input | $clog2(MAXVL+1) | Vector length, 0 to MAXVL |
| src_a_i | input | MAXVL*EW | First operand elements, element i at bits i*EW upward |
| src_b_i | input | MAXVL*EW | Second operand elements |
| cmp_op_i | input | 3 | Compare code |
| spred_mask_i | input | MAXVL | Source predicate mask |
| spred_inv_i | input | 1 | Source predicate invert |
| spred_zero_i | input | 1 | Source predicate zeroing |
| ffirst_i | input | 1 | Fail-on-first enable |
| dpred_en_i | input | 1 | Destination predicate present |
| dpred_inv_i | input | 1 | Destination predicate invert |
| dpred_zero_i | input | 1 | Destination predicate zeroing |
| done_o | output | 1 | Evaluation finished, one-cycle pulse |
| result_o | output | MAXVL | Result mask |
| dpred_we_o | output | 1 | Destination predicate write enable |
| taken_o | output | 1 | Branch decision |

## Verification
The hardest case to reach from the ports combines fail-on-first with sparse masks. A failing element must be active and must come before later elements that would otherwise change the mask. Only then do the early stop, the untouched tail bits and the shorter latency all become visible. The bench sweeps every compare code, every combination of the six flag inputs and every VL from 0 to 4. It draws element data so that equal, smaller and larger pairs occur often, and draws masks that leave gaps, so that stops at every position arise against each consensus rule.

// File: rtl/vcmp_branch_pkg.sv
package vcmp_branch_pkg;
  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_LT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_LTU = 3'd6,
    CMP_GEU = 3'd7
  } cmp_op_e;

  // {invert, zeroing} of the destination predicate
  typedef enum logic [1:0] {
    RULE_ALL  = 2'b00,
    RULE_ANY  = 2'b01,
    RULE_NALL = 2'b10,
    RULE_NONE = 2'b11
  } rule_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } state_e;
endpackage

// File: rtl/vcmp_elem_cmp.sv
module vcmp_elem_cmp
  import vcmp_branch_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [2:0]    op_i,
  output logic          pass_o
);
  logic lt_s, lt_u;

  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;

  always_comb begin
    case (cmp_op_e'(op_i))
      CMP_EQ:  pass_o = (a_i == b_i);
      CMP_NE:  pass_o = (a_i != b_i);
      CMP_LT:  pass_o = lt_s;
      CMP_GE:  pass_o = !lt_s;
      CMP_LTU: pass_o = lt_u;
      CMP_GEU: pass_o = !lt_u;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcmp_consensus.sv
module vcmp_consensus
  import vcmp_branch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] result_i,
  input  logic [N-1:0] ps_i,
  input  logic [1:0]   rule_i,
  output logic         take_o
);
  logic covered;

  assign covered = ((result_i & ps_i) == result_i);

  always_comb begin
    case (rule_e'(rule_i))
      RULE_ALL:  take_o = covered;
      RULE_NALL: take_o = !covered;
      RULE_ANY:  take_o = (result_i != '0);
      default:   take_o = (result_i == '0);
    endcase
  end
endmodule

// File: rtl/vcmp_branch.sv
module vcmp_branch
  import vcmp_branch_pkg::*;
#(
  parameter int EW    = 8,
  parameter int MAXVL = 8,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int DW   = MAXVL * EW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [DW-1:0]    src_a_i,
  input  logic [DW-1:0]    src_b_i,
  input  logic [2:0]       cmp_op_i,
  input  logic [MAXVL-1:0] spred_mask_i,
  input  logic             spred_inv_i,
  input  logic             spred_zero_i,
  input  logic             ffirst_i,
  input  logic             dpred_en_i,
  input  logic             dpred_inv_i,
  input  logic             dpred_zero_i,
  output logic             done_o,
  output logic [MAXVL-1:0] result_o,
  output logic             dpred_we_o,
  output logic             taken_o
);
  state_e           state_q;
  logic [IW-1:0]    idx_q;
  logic [VLW-1:0]   vl_q;
  logic [DW-1:0]    a_q, b_q;
  logic [2:0]       op_q;
  logic [MAXVL-1:0] ps_q, res_q, res_n, vlm, vlm_q;
  logic [1:0]       rule_q;
  logic             ffirst_q, den_q;
  logic             done_q, we_q, taken_q;
  logic             pass, take, stop, last;

  always_comb begin
    for (int i = 0; i < MAXVL; i++) vlm[i] = (VLW'(i) < vl_i);
  end

  vcmp_elem_cmp #(.EW(EW)) u_cmp (
    .a_i    (a_q[int'(idx_q)*EW +: EW]),
    .b_i    (b_q[int'(idx_q)*EW +: EW]),
    .op_i   (op_q),
    .pass_o (pass)
  );

  vcmp_consensus #(.N(MAXVL)) u_cons (
    .result_i (res_q),
    .ps_i     (ps_q),
    .rule_i   (rule_q),
    .take_o   (take)
  );

  assign last = ((VLW'(idx_q) + VLW'(1)) == vl_q);

  always_comb begin
    res_n = res_q;
    stop  = 1'b0;
    if (ps_q[idx_q]) begin
      res_n[idx_q] = pass;
      stop         = ffirst_q && !pass;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      vl_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      op_q     <= '0;
      ps_q     <= '0;
      res_q    <= '0;
      vlm_q    <= '0;
      rule_q   <= '0;
      ffirst_q <= 1'b0;
      den_q    <= 1'b0;
      done_q   <= 1'b0;
      we_q     <= 1'b0;
      taken_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          a_q      <= src_a_i;
          b_q      <= src_b_i;
          op_q     <= cmp_op_i;
          vl_q     <= vl_i;
          vlm_q    <= vlm;
          ps_q     <= (spred_inv_i ? ~spred_mask_i : spred_mask_i) & vlm;
          res_q    <= (!dpred_en_i || spred_zero_i) ? vlm : '0;
          rule_q   <= dpred_en_i ? {dpred_inv_i, dpred_zero_i} : 2'b00;
          ffirst_q <= ffirst_i;
          den_q    <= dpred_en_i;
          idx_q    <= '0;
          state_q  <= (vl_i == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          res_q <= res_n;
          idx_q <= idx_q + IW'(1);
          if (stop || last) state_q <= ST_FIN;
        end
        default: begin
          done_q  <= 1'b1;
          we_q    <= den_q;
          taken_q <= take;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign done_o     = done_q;
  assign dpred_we_o = we_q;
  assign taken_o    = taken_q;
  assign result_o   = res_q;

  // latency window counter for the checks below
  logic [VLW:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (state_q == ST_IDLE && start_i) lat_q <= '0;
    else if (state_q != ST_IDLE) lat_q <= lat_q + 1'b1;
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_latency_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q <= ({1'b0, vl_q} + 1'b1)));

  a_r8_we_only_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpred_we_o |-> done_o);

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> ($stable(result_o) && $stable(taken_o)));

  a_r4_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((result_o & ~vlm_q) == '0));
endmodule

// File: tb/sim_vcmp_branch.sv
`timescale 1ns/1ps
module sim_vcmp_branch;
  localparam int EW    = 4;
  localparam int MAXVL = 4;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int DW    = MAXVL * EW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [VLW-1:0]   vl = '0;
  logic [DW-1:0]    sa = '0, sb = '0;
  logic [2:0]       op = '0;
  logic [MAXVL-1:0] smask = '0;
  logic             sinv = 0, szero = 0, ff = 0, den = 0, dinv = 0, dzero = 0;
  logic             done, we, taken;
  logic [MAXVL-1:0] res;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vcmp_branch #(.EW(EW), .MAXVL(MAXVL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_a_i(sa), .src_b_i(sb), .cmp_op_i(op), .spred_mask_i(smask),
    .spred_inv_i(sinv), .spred_zero_i(szero), .ffirst_i(ff),
    .dpred_en_i(den), .dpred_inv_i(dinv), .dpred_zero_i(dzero),
    .done_o(done), .result_o(res), .dpred_we_o(we), .taken_o(taken)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pass_f(input int c, input int a, input int b);
    int as_, bs_;
    as_ = (a >= (1 << (EW - 1))) ? a - (1 << EW) : a;
    bs_ = (b >= (1 << (EW - 1))) ? b - (1 << EW) : b;
    case (c)
      0: return a == b;
      1: return a != b;
      4: return as_ < bs_;
      5: return as_ >= bs_;
      6: return a < b;
      7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(done == 0 && we == 0 && taken == 0 && res == 0, "R1 reset", {done, we, taken, res}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(done == 0 && we == 0 && taken == 0 && res == 0, "R1 after release", {done, we, taken, res}, 0);

    for (int v = 0; v <= MAXVL; v++) begin
      for (int c = 0; c < 8; c++) begin
        for (int f = 0; f < 64; f++) begin
          int vmask, ps, er, n, got, rule, exp_take, a, b;
          bit inv_r, zr_r, hold_ok;
          logic [MAXVL-1:0] res_keep;
          logic             tk_keep;
          @(negedge clk);
          vl = VLW'(v);
          op = 3'(c);
          {sinv, szero, ff, den, dinv, dzero} = 6'(f);
          smask = MAXVL'($urandom);
          for (int i = 0; i < MAXVL; i++) begin
            a = $urandom % (1 << EW);
            b = ($urandom % 3 == 0) ? a : $urandom % (1 << EW);
            sa[i*EW +: EW] = EW'(a);
            sb[i*EW +: EW] = EW'(b);
          end
          // reference model
          vmask = (1 << v) - 1;
          ps = (sinv ? ~int'(smask) : int'(smask)) & vmask;
          er = (!den || szero) ? vmask : 0;
          n = 0;
          for (int i = 0; i < v; i++) begin
            n++;
            if (ps[i]) begin
              if (pass_f(c, int'(sa[i*EW +: EW]), int'(sb[i*EW +: EW]))) er |= (1 << i);
              else begin
                er &= ~(1 << i);
                if (ff) break;
              end
            end
          end
          inv_r = den & dinv;
          zr_r  = den & dzero;
          rule  = {inv_r, zr_r};
          case (rule)
            0: exp_take = ((er & ps) == er);
            2: exp_take = ((er & ps) != er);
            1: exp_take = (er != 0);
            default: exp_take = (er == 0);
          endcase
          start = 1'b1;
          @(posedge clk); #1;
          start = 1'b0;
          got = -1;
          for (int k = 1; k <= 2 * MAXVL + 4; k++) begin
            @(posedge clk); #1;
            if (done) begin
              got = k;
              break;
            end
          end
          chk(got == n + 1, "R9 done latency", got, n + 1);
          chk(int'(res) == er, "R2/R3/R4/R5/R6 result mask", int'(res), er);
          chk(taken == exp_take[0], "R7/R8 taken", int'(taken), exp_take);
          chk(we == den, "R8 write enable", int'(we), int'(den));
          res_keep = res;
          tk_keep  = taken;
          @(posedge clk); #1;
          chk(done == 0 && we == 0, "R9 single-cycle done", {done, we}, 0);
          @(posedge clk); #1;
          hold_ok = (res == res_keep) && (taken == tk_keep);
          chk(hold_ok, "R10 outputs hold", {taken, res}, {tk_keep, res_keep});
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule